// File: doc/BRIEF.md
# Digital CDS Averaging Accumulator

This block sits behind one column converter of a time-gated imager. Each measurement delivers two 13-bit codes in a fixed order. The first is the level captured just after the pixel is reset. The second is the level captured after the gated photocurrent integration. The block subtracts the second code from the first to cancel the pixel's reset level and offset. It then sums the signed differences over a power-of-two number of repeated measurements, from 1 to 64, and divides by that number with an arithmetic right shift.

When a set is complete, one averaged result leaves the block with a single-cycle strobe. For gate-delay sweeps, a delta mode is available. In delta mode the block outputs the change between consecutive averaged results instead of the averages themselves, so a constant offset drops out.

A start-of-frame pulse empties the block and loads its configuration. An integrated code that arrives with no reset code waiting is dropped and raises an error flag.

Top module: `cds_avg_accum`

## Requirements
- R1: When a reset code (`code_kind_i`=0) is followed by an integrated code (`code_kind_i`=1), the block forms the difference reset code minus integrated code as a 14-bit signed value.
- R2: A second reset code that arrives before any integrated code replaces the waiting reset code. Only the most recent reset code is paired.
- R3: The averaging exponent k is taken from `avg_log2_i` at start of frame, and any value above 6 is used as 6. After 2^k differences, the result equals the sum of those differences shifted right arithmetically by k, which rounds toward minus infinity. Changing `avg_log2_i` without a start-of-frame pulse has no effect.
- R4: Each result raises `res_vld_o` for exactly one cycle. The strobe is visible after the third rising edge counting the edge that samples the set's last integrated code. No strobe appears while a set is still incomplete.
- R5: An integrated code that arrives while no reset code is waiting is discarded and does not count toward the set. It sets `orphan_err_o`, which stays high until the next start of frame.
- R6: With `delta_mode_i`=1 captured at start of frame, each result is the current average minus the previous average of the same frame. The first result of a frame is taken against zero. The result is 15 bits signed.
- R7: `sof_i` clears the running sum, the measurement count, the waiting reset code, the previous average and the error flag. A code presented in the same cycle as `sof_i` is ignored.
- R8: After reset, `res_vld_o`, `res_o` and `orphan_err_o` are 0, k is 0 and delta mode is off.
- R9: Sixty-four full-scale differences of +8191 or of -8191 accumulate without overflow and average to exactly +8191 or -8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-frame pulse; clears state and loads configuration |
| code_vld_i | input | 1 | Code strobe |
| code_kind_i | input | 1 | 0 = reset-level code, 1 = integrated code |
| code_i | input | 13 | Converter code, unsigned |
| avg_log2_i | input | 3 | Averaging exponent k, captured at start of frame |
| delta_mode_i | input | 1 | 1 = output difference of consecutive averages, captured at start of frame |
| res_vld_o | output | 1 | Result strobe, one cycle |
| res_o | output | 15 | Signed result |
| orphan_err_o | output | 1 | Sticky flag for a discarded integrated code |

## Verification
A result passes three registers on its way out: the difference register, the averaging register and the output register. It is therefore due after the third rising edge counting the edge that samples the last integrated code. The bench drives inputs on falling edges. After every completing measurement it looks at the falling edges that follow. The strobe must be low at the first two, high with the expected value at the third, and low again at the fourth. For incomplete sets and discarded codes, the bench watches the same three-edge window and requires the strobe to stay low. Error-flag and configuration effects are read at the ports before the next stimulus.

// File: rtl/cds_avg_pkg.sv
package cds_avg_pkg;

    typedef enum logic {
        KIND_RST = 1'b0,
        KIND_INT = 1'b1
    } sample_kind_e;

endpackage

// File: rtl/cds_pair.sv
module cds_pair
    import cds_avg_pkg::*;
#(
    parameter int CODE_W = 13,
    localparam int DIFF_W = CODE_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sof_i,
    input  logic                     vld_i,
    input  logic                     kind_i,
    input  logic [CODE_W-1:0]        code_i,
    output logic                     diff_vld_o,
    output logic signed [DIFF_W-1:0] diff_o,
    output logic                     err_o
);

    localparam int MAX_MAG = (1 << CODE_W) - 1;

    typedef struct packed {
        logic              pend;
        logic [CODE_W-1:0] hold;
        logic              dvld;
        logic [DIFF_W-1:0] diff;
        logic              err;
    } pair_st_t;

    pair_st_t st_d, st_q;
    logic signed [DIFF_W-1:0] diff_calc;

    always_comb begin
        diff_calc = $signed({1'b0, st_q.hold}) - $signed({1'b0, code_i});
        st_d      = st_q;
        st_d.dvld = 1'b0;
        if (sof_i) begin
            st_d.pend = 1'b0;
            st_d.err  = 1'b0;
        end else if (vld_i) begin
            if (kind_i == KIND_RST) begin
                st_d.hold = code_i;
                st_d.pend = 1'b1;
            end else if (st_q.pend) begin
                st_d.diff = diff_calc;
                st_d.dvld = 1'b1;
                st_d.pend = 1'b0;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign diff_vld_o = st_q.dvld;
    assign diff_o     = $signed(st_q.diff);
    assign err_o      = st_q.err;

    AST_DIFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        diff_vld_o |-> (diff_o <= MAX_MAG && diff_o >= -MAX_MAG)); // R1

    AST_ORPHAN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && kind_i == KIND_INT && !st_q.pend && !sof_i) |=> (!diff_vld_o && err_o)); // R5

    AST_PAIR_SOF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> (!st_q.pend && !err_o && !diff_vld_o)); // R7

endmodule

// File: rtl/cds_accum.sv
module cds_accum #(
    parameter int DIFF_W   = 14,
    parameter int MAX_LOG2 = 6,
    localparam int LOG_W   = $clog2(MAX_LOG2 + 1),
    localparam int CNT_W   = (MAX_LOG2 < 1) ? 1 : MAX_LOG2,
    localparam int ACC_W   = DIFF_W + MAX_LOG2,
    localparam int EXT_W   = ACC_W - DIFF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sof_i,
    input  logic [LOG_W-1:0]         log2_cfg_i,
    input  logic                     diff_vld_i,
    input  logic signed [DIFF_W-1:0] diff_i,
    output logic                     avg_vld_o,
    output logic signed [DIFF_W-1:0] avg_o
);

    typedef struct packed {
        logic [LOG_W-1:0]  k;
        logic [CNT_W-1:0]  cnt;
        logic [ACC_W-1:0]  acc;
        logic              avg_vld;
        logic [DIFF_W-1:0] avg;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic [LOG_W-1:0]         k_clamped;
    logic [CNT_W:0]           one_hot;
    logic [CNT_W-1:0]         tgt;
    logic [ACC_W-1:0]         diff_ext;
    logic signed [ACC_W-1:0]  sum;
    logic signed [ACC_W-1:0]  shifted;

    generate
        if (EXT_W > 0) begin : g_ext
            assign diff_ext = {{EXT_W{diff_i[DIFF_W-1]}}, diff_i};
        end else begin : g_noext
            assign diff_ext = diff_i;
        end
    endgenerate

    always_comb begin
        k_clamped = (log2_cfg_i > LOG_W'(MAX_LOG2)) ? LOG_W'(MAX_LOG2) : log2_cfg_i;
        one_hot   = (CNT_W + 1)'(1) << st_q.k;
        tgt       = CNT_W'(one_hot - (CNT_W + 1)'(1));
        sum       = $signed(st_q.acc) + $signed(diff_ext);
        shifted   = sum >>> st_q.k;

        st_d         = st_q;
        st_d.avg_vld = 1'b0;
        if (sof_i) begin
            st_d.acc = '0;
            st_d.cnt = '0;
            st_d.k   = k_clamped;
        end else if (diff_vld_i) begin
            if (st_q.cnt == tgt) begin
                st_d.avg_vld = 1'b1;
                st_d.avg     = DIFF_W'(shifted);
                st_d.acc     = '0;
                st_d.cnt     = '0;
            end else begin
                st_d.acc = sum;
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign avg_vld_o = st_q.avg_vld;
    assign avg_o     = $signed(st_q.avg);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= tgt); // R4

    AST_K_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.k <= LOG_W'(MAX_LOG2)); // R3

    AST_AVG_NEEDS_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        avg_vld_o |-> $past(diff_vld_i)); // R4

    AST_ACC_SOF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> (st_q.cnt == '0 && st_q.acc == '0 && !avg_vld_o)); // R7

endmodule

// File: rtl/cds_delta.sv
module cds_delta #(
    parameter int DIFF_W = 14,
    localparam int RES_W = DIFF_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sof_i,
    input  logic                     mode_cfg_i,
    input  logic                     avg_vld_i,
    input  logic signed [DIFF_W-1:0] avg_i,
    output logic                     res_vld_o,
    output logic signed [RES_W-1:0]  res_o
);

    typedef struct packed {
        logic              mode;
        logic [DIFF_W-1:0] prev;
        logic              rvld;
        logic [RES_W-1:0]  res;
    } dlt_st_t;

    dlt_st_t st_d, st_q;
    logic signed [RES_W-1:0] avg_ext;
    logic signed [RES_W-1:0] prev_ext;

    always_comb begin
        avg_ext  = $signed({avg_i[DIFF_W-1], avg_i});
        prev_ext = $signed({st_q.prev[DIFF_W-1], st_q.prev});

        st_d      = st_q;
        st_d.rvld = 1'b0;
        if (sof_i) begin
            st_d.prev = '0;
            st_d.mode = mode_cfg_i;
        end else if (avg_vld_i) begin
            st_d.rvld = 1'b1;
            st_d.prev = avg_i;
            st_d.res  = st_q.mode ? (avg_ext - prev_ext) : avg_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld_o = st_q.rvld;
    assign res_o     = $signed(st_q.res);

    AST_RES_FROM_AVG: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |-> $past(avg_vld_i)); // R4

    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_o && !st_q.mode) |-> (res_o == $signed({$past(avg_i[DIFF_W-1]), $past(avg_i)}))); // R3

    AST_DELTA_SOF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> (st_q.prev == '0 && !res_vld_o)); // R7

endmodule

// File: rtl/cds_avg_accum.sv
module cds_avg_accum #(
    parameter int CODE_W   = 13,
    parameter int MAX_LOG2 = 6,
    localparam int LOG_W   = $clog2(MAX_LOG2 + 1),
    localparam int DIFF_W  = CODE_W + 1,
    localparam int RES_W   = DIFF_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sof_i,
    input  logic                    code_vld_i,
    input  logic                    code_kind_i,
    input  logic [CODE_W-1:0]       code_i,
    input  logic [LOG_W-1:0]        avg_log2_i,
    input  logic                    delta_mode_i,
    output logic                    res_vld_o,
    output logic signed [RES_W-1:0] res_o,
    output logic                    orphan_err_o
);

    logic                     diff_vld;
    logic signed [DIFF_W-1:0] diff;
    logic                     avg_vld;
    logic signed [DIFF_W-1:0] avg;

    cds_pair #(
        .CODE_W (CODE_W)
    ) pair_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof_i),
        .vld_i      (code_vld_i),
        .kind_i     (code_kind_i),
        .code_i     (code_i),
        .diff_vld_o (diff_vld),
        .diff_o     (diff),
        .err_o      (orphan_err_o)
    );

    cds_accum #(
        .DIFF_W   (DIFF_W),
        .MAX_LOG2 (MAX_LOG2)
    ) accum_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof_i),
        .log2_cfg_i (avg_log2_i),
        .diff_vld_i (diff_vld),
        .diff_i     (diff),
        .avg_vld_o  (avg_vld),
        .avg_o      (avg)
    );

    cds_delta #(
        .DIFF_W (DIFF_W)
    ) delta_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof_i),
        .mode_cfg_i (delta_mode_i),
        .avg_vld_i  (avg_vld),
        .avg_i      (avg),
        .res_vld_o  (res_vld_o),
        .res_o      (res_o)
    );

endmodule

// File: tb/cds_avg_accum_tb_top.sv
module cds_avg_accum_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_i = 1'b0;
    logic        code_vld_i = 1'b0;
    logic        code_kind_i = 1'b0;
    logic [12:0] code_i = '0;
    logic [2:0]  avg_log2_i = '0;
    logic        delta_mode_i = 1'b0;
    logic        res_vld_o;
    logic signed [14:0] res_o;
    logic        orphan_err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cds_avg_accum dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sof_i        (sof_i),
        .code_vld_i   (code_vld_i),
        .code_kind_i  (code_kind_i),
        .code_i       (code_i),
        .avg_log2_i   (avg_log2_i),
        .delta_mode_i (delta_mode_i),
        .res_vld_o    (res_vld_o),
        .res_o        (res_o),
        .orphan_err_o (orphan_err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_sof(input int k, input bit d);
        @(negedge clk);
        sof_i        = 1'b1;
        avg_log2_i   = 3'(k);
        delta_mode_i = d;
        @(negedge clk);
        sof_i = 1'b0;
    endtask

    task automatic send(input bit kind, input int code);
        @(negedge clk);
        code_vld_i  = 1'b1;
        code_kind_i = kind;
        code_i      = 13'(code);
        @(negedge clk);
        code_vld_i = 1'b0;
    endtask

    task automatic measure(input int r, input int i);
        send(1'b0, r);
        send(1'b1, i);
    endtask

    // called at the falling edge right after the edge that took the last code
    task automatic expect_res(input string tag, input int exp);
        chk({tag, " strobe low after 1 edge"}, int'(res_vld_o), 0);
        @(negedge clk);
        chk({tag, " strobe low after 2 edges"}, int'(res_vld_o), 0);
        @(negedge clk);
        chk({tag, " strobe high after 3 edges"}, int'(res_vld_o), 1);
        chk({tag, " value"}, int'(res_o), exp);
        @(negedge clk);
        chk({tag, " strobe one cycle"}, int'(res_vld_o), 0);
    endtask

    task automatic expect_none(input string tag);
        for (int c = 0; c < 3; c++) begin
            chk({tag, " no strobe"}, int'(res_vld_o), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        chk("R8 res_vld_o after reset", int'(res_vld_o), 0);
        chk("R8 res_o after reset", int'(res_o), 0);
        chk("R8 orphan_err_o after reset", int'(orphan_err_o), 0);
        // k=0 and delta off out of reset: one pair gives its own difference
        measure(300, 100);
        expect_res("R8 default k=0", 200);
    endtask

    task automatic t_single();
        do_sof(0, 1'b0);
        measure(5000, 1000);
        expect_res("R1 positive difference", 4000);
        measure(100, 3000);
        expect_res("R1 negative difference", -2900);
    endtask

    task automatic t_average();
        int d[4] = '{10, -3, 7, 1};
        do_sof(2, 1'b0);
        for (int j = 0; j < 4; j++) begin
            measure(4000 + d[j], 4000);
            if (j < 3) expect_none("R4 partial set");
        end
        expect_res("R3 floor(15/4)", 15 >>> 2);
        for (int j = 0; j < 4; j++) begin
            measure(4000, 4000 + d[j]);
            if (j < 3) expect_none("R4 partial set neg");
        end
        expect_res("R3 floor(-15/4)", (-15) >>> 2);
    endtask

    task automatic t_replace();
        do_sof(0, 1'b0);
        send(1'b0, 10);
        send(1'b0, 500);
        send(1'b1, 100);
        expect_res("R2 latest reset code used", 400);
    endtask

    task automatic t_orphan();
        do_sof(1, 1'b0);
        send(1'b1, 1234);
        chk("R5 error flag set", int'(orphan_err_o), 1);
        expect_none("R5 orphan discarded");
        measure(600, 100);
        expect_none("R5 orphan not counted");
        measure(300, 100);
        expect_res("R5 set excludes orphan", (500 + 200) >>> 1);
        chk("R5 error flag sticky", int'(orphan_err_o), 1);
        do_sof(0, 1'b0);
        chk("R7 sof clears error flag", int'(orphan_err_o), 0);
    endtask

    task automatic t_delta();
        do_sof(1, 1'b1);
        measure(1100, 1000);
        measure(1200, 1000);
        expect_res("R6 first delta against zero", 150);
        measure(1040, 1000);
        measure(1060, 1000);
        expect_res("R6 delta of consecutive averages", 50 - 150);
        do_sof(1, 1'b1);
        measure(1010, 1000);
        measure(1010, 1000);
        expect_res("R6 new frame restarts from zero", 10);
    endtask

    task automatic t_fullscale();
        do_sof(7, 1'b0);
        for (int j = 0; j < 63; j++) begin
            measure(8191, 0);
        end
        expect_none("R3 clamp to 64 no result after 63");
        measure(8191, 0);
        expect_res("R9 positive full scale", 8191);
        for (int j = 0; j < 64; j++) begin
            measure(0, 8191);
        end
        expect_res("R9 negative full scale", -8191);
    endtask

    task automatic t_sof_cases();
        do_sof(2, 1'b0);
        measure(2000, 1000);
        measure(2000, 1000);
        do_sof(2, 1'b0);
        for (int j = 0; j < 4; j++) begin
            measure(108, 100);
        end
        expect_res("R7 sum cleared by sof", 8);
        // config changes without sof are ignored
        do_sof(0, 1'b0);
        avg_log2_i   = 3'd3;
        delta_mode_i = 1'b1;
        measure(900, 100);
        expect_res("R3 k held until sof", 800);
        // code coinciding with sof is dropped
        @(negedge clk);
        sof_i       = 1'b1;
        code_vld_i  = 1'b1;
        code_kind_i = 1'b0;
        code_i      = 13'd77;
        @(negedge clk);
        sof_i      = 1'b0;
        code_vld_i = 1'b0;
        send(1'b1, 10);
        chk("R7 code with sof ignored", int'(orphan_err_o), 1);
        expect_none("R7 no pair after dropped code");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_single();
        t_average();
        t_replace();
        t_orphan();
        t_delta();
        t_fullscale();
        t_sof_cases();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule